// File: doc/BRIEF.md
# Chained FIFO Depth-Expansion Token Controller

This block is the control logic that turns several identical FIFO slices into one deeper FIFO. The slices sit on a ring. Each slice keeps its own write pointer, read pointer and occupancy count. It also holds two ownership tokens: one for writing and one for reading. A slice forwards the shared write request to its memory only while it owns the write token and is not full. Reads follow the same rule with the read token and the empty condition. When a slice writes its last physical location, it gives up the write token in that same cycle. It pulses its write hand-off line low, and the next slice on the ring takes the token at the following clock edge. Reads hand off the read token the same way on a second line.

At reset every pointer returns to location zero and every slice is empty. Only the slice whose first-load input is held low at reset starts with both tokens. The composite empty flag rises only when every slice is empty, and the composite full flag only when every slice is full. The slice memories sit outside the block. They are written and read through the per-slice strobes and addresses the block drives.

Top module: `fifo_chain_ctrl`

## Requirements
- R1: While reset is held and directly after it, all write and read addresses are 0, `all_empty` is 1 and `all_full` is 0. Only the slice whose `first_load_n` bit is 0 owns the tokens, so the first write goes to that slice at address 0.
- R2: At most one bit of `wr_strobe` is 1 in any cycle. It is the bit of the slice that owns the write token, and only when `wr_req` is 1 and that slice is not full.
- R3: At most one bit of `rd_strobe` is 1 in any cycle. It is the bit of the slice that owns the read token, and only when `rd_req` is 1 and that slice is not empty.
- R4: A slice's write (read) address starts at 0 and steps by one on each of its write (read) strobes. It wraps from SLICE_DEPTH-1 to 0.
- R5: In the cycle a slice strobes a write at address SLICE_DEPTH-1, its `xo_wr_n` bit is 0 and all other bits are 1. From the next cycle, writes go to slice (k+1) mod NUM_SLICES.
- R6: In the cycle a slice strobes a read at address SLICE_DEPTH-1, its `xo_rd_n` bit is 0. From the next cycle, reads come from slice (k+1) mod NUM_SLICES.
- R7: `all_full` is 1 exactly when every slice holds SLICE_DEPTH entries. While it is 1, `wr_req` produces no write strobe.
- R8: `all_empty` is 1 exactly when every slice holds no entries. While it is 1, `rd_req` produces no read strobe.
- R9: Data written through the strobes is read back in write order, across slice boundaries and around the ring.
- R10: A read and a write requested in the same cycle are both carried out when the FIFO is neither empty nor full.
- R11: Any slice can be chosen as the start of the chain by holding its `first_load_n` bit at 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| first_load_n | input | NUM_SLICES | Per-slice first-load select, active low, exactly one bit 0 |
| wr_req | input | 1 | Shared write request |
| rd_req | input | 1 | Shared read request |
| wr_strobe | output | NUM_SLICES | Gated write strobe per slice memory |
| rd_strobe | output | NUM_SLICES | Gated read strobe per slice memory |
| wr_addr | output | NUM_SLICES*AW | Write location per slice, AW bits each |
| rd_addr | output | NUM_SLICES*AW | Read location per slice, AW bits each |
| xo_wr_n | output | NUM_SLICES | Write-token hand-off pulse per slice, active low |
| xo_rd_n | output | NUM_SLICES | Read-token hand-off pulse per slice, active low |
| all_empty | output | 1 | Composite empty flag |
| all_full | output | 1 | Composite full flag |

## Verification
Strobes, addresses and hand-off pulses are combinational from the requests and the registered state. They are due in the same cycle as the request, so the bench drives each request at the falling edge and checks them one nanosecond later. Token moves, pointer steps and flag changes take effect at the next rising edge. They show up in the next step's checks, which the bench predicts from its running write and read totals: slice = (first + n / depth) mod slices, address = n mod depth, occupancy = writes minus reads. Read data is taken from the bench's slice memories at the read strobe and compared with the value recorded for that position in the write order.

// File: rtl/chain_pkg.sv
package chain_pkg;

  // Ring neighbours of a slice index.
  function automatic int unsigned ring_prev(input int unsigned idx, input int unsigned n);
    return (idx == 0) ? n - 1 : idx - 1;
  endfunction

  function automatic int unsigned ring_next(input int unsigned idx, input int unsigned n);
    return (idx + 1 == n) ? 0 : idx + 1;
  endfunction

  // Address width for a slice depth (at least one bit).
  function automatic int unsigned addr_bits(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

  // Count width able to hold 0..depth.
  function automatic int unsigned count_bits(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction

  typedef struct packed {
    logic wr_pass;
    logic rd_pass;
  } handoff_t;

endpackage

// File: rtl/slice_token_ctrl.sv
module slice_token_ctrl
  import chain_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW = addr_bits(DEPTH),
  localparam int unsigned CW = count_bits(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          first_load_n,
  input  logic          wr_req,
  input  logic          rd_req,
  input  logic          xi_wr_n,
  input  logic          xi_rd_n,
  output logic          wr_stb,
  output logic          rd_stb,
  output logic [AW-1:0] wr_loc,
  output logic [AW-1:0] rd_loc,
  output logic          xo_wr_n,
  output logic          xo_rd_n,
  output logic          is_empty,
  output logic          is_full,
  output logic          wtok_o,
  output logic          rtok_o
);

  localparam logic [AW-1:0] LAST_LOC = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  function automatic logic [AW-1:0] loc_step(input logic [AW-1:0] p);
    return (p == LAST_LOC) ? '0 : p + AW'(1);
  endfunction

  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] fill;
  logic          wtok, rtok;
  handoff_t      pass;

  assign is_empty = (fill == '0);
  assign is_full  = (fill == FULL_CNT);

  assign wr_stb = wr_req & wtok & ~is_full;
  assign rd_stb = rd_req & rtok & ~is_empty;

  assign pass.wr_pass = wr_stb & (wptr == LAST_LOC);
  assign pass.rd_pass = rd_stb & (rptr == LAST_LOC);

  assign xo_wr_n = ~pass.wr_pass;
  assign xo_rd_n = ~pass.rd_pass;
  assign wr_loc  = wptr;
  assign rd_loc  = rptr;
  assign wtok_o  = wtok;
  assign rtok_o  = rtok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
      wtok <= ~first_load_n;
      rtok <= ~first_load_n;
    end else begin
      // Token is dropped on the last-location access, taken on an incoming pulse.
      wtok <= (wtok & ~pass.wr_pass) | ~xi_wr_n;
      rtok <= (rtok & ~pass.rd_pass) | ~xi_rd_n;
      if (wr_stb) wptr <= loc_step(wptr);
      if (rd_stb) rptr <= loc_step(rptr);
      fill <= fill + CW'(wr_stb) - CW'(rd_stb);
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FULL_CNT);

  assert_wptr_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wptr == LAST_LOC) |=> (wptr == '0));

  assert_rptr_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rptr == LAST_LOC) |=> (rptr == '0));

endmodule

// File: rtl/chain_flag_join.sv
module chain_flag_join #(
  parameter int unsigned NUM_SLICES = 3
) (
  input  logic [NUM_SLICES-1:0] slice_empty,
  input  logic [NUM_SLICES-1:0] slice_full,
  output logic                  all_empty,
  output logic                  all_full
);

  // A composite flag asserts only when every slice reports it.
  assign all_empty = &slice_empty;
  assign all_full  = &slice_full;

endmodule

// File: rtl/fifo_chain_ctrl.sv
module fifo_chain_ctrl
  import chain_pkg::*;
#(
  parameter int unsigned NUM_SLICES  = 3,
  parameter int unsigned SLICE_DEPTH = 4,
  localparam int unsigned AW = addr_bits(SLICE_DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SLICES-1:0]    first_load_n,
  input  logic                     wr_req,
  input  logic                     rd_req,
  output logic [NUM_SLICES-1:0]    wr_strobe,
  output logic [NUM_SLICES-1:0]    rd_strobe,
  output logic [NUM_SLICES*AW-1:0] wr_addr,
  output logic [NUM_SLICES*AW-1:0] rd_addr,
  output logic [NUM_SLICES-1:0]    xo_wr_n,
  output logic [NUM_SLICES-1:0]    xo_rd_n,
  output logic                     all_empty,
  output logic                     all_full
);

  logic [NUM_SLICES-1:0] slice_empty, slice_full;
  logic [NUM_SLICES-1:0] wtok, rtok;

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
    localparam int unsigned PREV = ring_prev(k, NUM_SLICES);
    localparam int unsigned NEXT = ring_next(k, NUM_SLICES);

    slice_token_ctrl #(.DEPTH(SLICE_DEPTH)) u_slice (
      .clk          (clk),
      .rst_n        (rst_n),
      .first_load_n (first_load_n[k]),
      .wr_req       (wr_req),
      .rd_req       (rd_req),
      .xi_wr_n      (xo_wr_n[PREV]),
      .xi_rd_n      (xo_rd_n[PREV]),
      .wr_stb       (wr_strobe[k]),
      .rd_stb       (rd_strobe[k]),
      .wr_loc       (wr_addr[k*AW +: AW]),
      .rd_loc       (rd_addr[k*AW +: AW]),
      .xo_wr_n      (xo_wr_n[k]),
      .xo_rd_n      (xo_rd_n[k]),
      .is_empty     (slice_empty[k]),
      .is_full      (slice_full[k]),
      .wtok_o       (wtok[k]),
      .rtok_o       (rtok[k])
    );

    assert_wtok_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !xo_wr_n[k] |=> wtok[NEXT]);

    assert_rtok_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !xo_rd_n[k] |=> rtok[NEXT]);
  end

  chain_flag_join #(.NUM_SLICES(NUM_SLICES)) u_flags (
    .slice_empty (slice_empty),
    .slice_full  (slice_full),
    .all_empty   (all_empty),
    .all_full    (all_full)
  );

  assert_one_writer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_strobe));

  assert_one_reader_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_strobe));

  assert_full_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    all_full |-> (wr_strobe == '0));

  assert_empty_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    all_empty |-> (rd_strobe == '0));

endmodule

// File: tb/sim_fifo_chain_ctrl.sv
`timescale 1ns/1ps
module sim_fifo_chain_ctrl;

  localparam int NS  = 3;
  localparam int D   = 4;
  localparam int AW  = 2;
  localparam int CAP = NS * D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0] first_load_n = '1;
  logic wr_req = 1'b0, rd_req = 1'b0;
  logic [7:0] wdata = '0;
  logic [NS-1:0] wr_strobe, rd_strobe, xo_wr_n, xo_rd_n;
  logic [NS*AW-1:0] wr_addr, rd_addr;
  logic all_empty, all_full;

  always #2.5 clk = ~clk;

  fifo_chain_ctrl #(.NUM_SLICES(NS), .SLICE_DEPTH(D)) u0 (
    .clk(clk), .rst_n(rst_n), .first_load_n(first_load_n),
    .wr_req(wr_req), .rd_req(rd_req),
    .wr_strobe(wr_strobe), .rd_strobe(rd_strobe),
    .wr_addr(wr_addr), .rd_addr(rd_addr),
    .xo_wr_n(xo_wr_n), .xo_rd_n(xo_rd_n),
    .all_empty(all_empty), .all_full(all_full)
  );

  // Slice memories, written through the block's strobes.
  logic [7:0] mem [NS][D];
  always @(posedge clk) begin
    for (int k = 0; k < NS; k++)
      if (wr_strobe[k]) mem[k][wr_addr[k*AW +: AW]] <= wdata;
  end

  int checks = 0, errors = 0;
  int first = 0, nw = 0, nr = 0;
  logic [7:0] refq [1024];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int f);
    @(negedge clk);
    rst_n = 1'b0; wr_req = 1'b0; rd_req = 1'b0;
    first_load_n = '1; first_load_n[f] = 1'b0;
    first = f; nw = 0; nr = 0;
    repeat (2) @(negedge clk);
    chk(wr_addr == '0 && rd_addr == '0, "R1 addresses in reset", int'(wr_addr), 0);
    rst_n = 1'b1;
    #1;
    chk(all_empty == 1'b1, "R1 empty after reset", all_empty, 1);
    chk(all_full == 1'b0, "R1 full after reset", all_full, 0);
  endtask

  task automatic step(input bit w, input bit r, input logic [7:0] d);
    int occ, ws, wa, rs, ra;
    bit wacc, racc;
    logic [NS-1:0] ew, er, exw, exr;
    @(negedge clk);
    wr_req = w; rd_req = r; wdata = d;
    #1;
    occ  = nw - nr;
    wacc = w && occ < CAP;
    racc = r && occ > 0;
    ws = (first + nw / D) % NS; wa = nw % D;
    rs = (first + nr / D) % NS; ra = nr % D;
    ew = '0; er = '0; exw = '1; exr = '1;
    if (wacc) begin ew[ws] = 1'b1; if (wa == D - 1) exw[ws] = 1'b0; end
    if (racc) begin er[rs] = 1'b1; if (ra == D - 1) exr[rs] = 1'b0; end
    chk(wr_strobe == ew, "R2 write strobe", wr_strobe, ew);
    chk(rd_strobe == er, "R3 read strobe", rd_strobe, er);
    if (wacc) chk(int'(wr_addr[ws*AW +: AW]) == wa, "R4 write address", wr_addr[ws*AW +: AW], wa);
    if (racc) chk(int'(rd_addr[rs*AW +: AW]) == ra, "R4 read address", rd_addr[rs*AW +: AW], ra);
    chk(xo_wr_n == exw, "R5 write hand-off", xo_wr_n, exw);
    chk(xo_rd_n == exr, "R6 read hand-off", xo_rd_n, exr);
    chk(all_full == (occ == CAP), "R7 composite full", all_full, occ == CAP);
    chk(all_empty == (occ == 0), "R8 composite empty", all_empty, occ == 0);
    if (racc) chk(mem[rs][rd_addr[rs*AW +: AW]] == refq[nr], "R9 read data order",
                  mem[rs][rd_addr[rs*AW +: AW]], refq[nr]);
    if (wacc) begin refq[nw] = d; nw++; end
    if (racc) nr++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d", nr, nw);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R11: every slice in turn starts the chain.
    for (int f = 0; f < NS; f++) begin
      do_reset(f);
      // R1: first write lands in the first-load slice at address 0.
      for (int i = 0; i < CAP + 2; i++) step(1'b1, 1'b0, 8'(f * 64 + i));   // R7 overflow attempts
      for (int i = 0; i < CAP + 2; i++) step(1'b0, 1'b1, 8'h00);           // R8 underflow attempts
      // R10: mixed and simultaneous traffic, wrapping the ring several times.
      for (int i = 0; i < 90; i++) step((i % 3) != 0, (i % 2) == 0 || i > 60, 8'(i * 7 + f));
      for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 8'(200 + i));
      for (int i = 0; i < CAP + 1; i++) step(1'b0, 1'b1, 8'h00);
      // Fill to full then read/write together: R10 at the full boundary.
      for (int i = 0; i < CAP; i++) step(1'b1, 1'b0, 8'(i + 100));
      for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 8'(i + 150));
      for (int i = 0; i < CAP + 1; i++) step(1'b0, 1'b1, 8'h00);
    end
    @(negedge clk);
    wr_req = 1'b0; rd_req = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule